// File: doc/BRIEF.md
# PAL-Style Progressive Composite Sync Generator

This block produces the timing skeleton of a monochrome, non-interlaced composite video signal that follows the PAL line rate. It runs from a single clock, nominally 24 MHz. Every duration is a whole number of microseconds multiplied by the clocks per microsecond, so each interval is an exact cycle count. Each frame is a fixed schedule of pulses and lines. It opens with a group of broad vertical pulses. A group of narrow equalising pulses follows, then the picture lines, then a closing group of narrow pulses. After the closing group the schedule starts again. Both kinds of vertical pulse occupy a half line of 32 µs. A picture line lasts 64 µs.

The outputs are an active-low sync level, a flag that marks the window in which pixels may be shown, and two one-cycle strobes: one at the start of each picture line and one at the start of each frame. A picture-line index is also provided. A pixel serialiser elsewhere uses the window flag to keep video at black during sync and porch, and uses the line index and line strobe to fetch its data.

Top module: `pal_sync_gen`

## Requirements
- R1: A synchronous active-high reset places the generator on the first cycle of the first broad pulse. While reset is high: the sync output is low, the window flag is low, both strobes are low, and the line index is 0.
- R2: A frame opens with N_VLONG (default 5) broad pulses. Each broad pulse is 30 µs with sync low, then 2 µs with sync high.
- R3: N_EQ_LEAD (default 5) narrow pulses follow the broad pulses. Each narrow pulse is 2 µs with sync low, then 30 µs with sync high.
- R4: N_LINES (default 304) picture lines follow the leading narrow pulses. Each picture line is 64 µs long: 4 µs with sync low, then an 8 µs porch with sync high, then a 52 µs active region with sync high.
- R5: The window flag is high for exactly 52 µs (1248 cycles at 24 MHz) in each picture line. It rises 12 µs (288 cycles) after the line's sync falling edge. It is never high while sync is low, and never high outside picture lines.
- R6: N_EQ_TRAIL (default 6) narrow pulses follow the last picture line, shaped as in R3. The next broad pulse follows at once. One frame therefore contains N_VLONG+N_EQ_LEAD+N_LINES+N_EQ_TRAIL sync falling edges.
- R7: The line strobe is high for one cycle. It coincides with the sync falling edge of every picture line, and with no other cycle.
- R8: The frame strobe is high for one cycle. It coincides with the sync falling edge of the first broad pulse of each frame, and with no other cycle.
- R9: The line index reads k during picture line k, for k from 0 to N_LINES-1. It changes only in the cycle the line strobe is high. Outside the picture lines it holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock, CLK_PER_US cycles per microsecond |
| rst_i | input | 1 | Synchronous reset, active high |
| sync_n_o | output | 1 | Composite sync level, low during sync |
| active_o | output | 1 | High during the active region of a picture line |
| line_start_o | output | 1 | One-cycle strobe at each picture line's sync fall |
| frame_start_o | output | 1 | One-cycle strobe at the first broad pulse's fall |
| line_idx_o | output | IDX_W | Current picture-line index |

## Verification
The bench builds the generator with two clocks per microsecond and six picture lines. All other parameters keep their defaults, so every pulse, porch and window keeps its proportions. A whole frame then lasts 1792 cycles, so several complete frames fit within the run. The behavioural model can therefore cover every phase boundary, including:
- the wrap from the closing narrow pulses back to the broad pulses;
- the hold of the line index across the vertical interval;
- its return to 0 on the next frame.

A reset applied inside a picture line checks that the schedule restarts cleanly from the first broad pulse.

// File: rtl/pal_sync_pkg.sv
package pal_sync_pkg;

    // Frame phases, in the order the schedule visits them.
    typedef enum logic [1:0] {
        PH_VLONG    = 2'd0,
        PH_EQ_LEAD  = 2'd1,
        PH_PICTURE  = 2'd2,
        PH_EQ_TRAIL = 2'd3
    } pal_phase_e;

    function automatic pal_phase_e phase_after(input pal_phase_e ph);
        case (ph)
            PH_VLONG:   return PH_EQ_LEAD;
            PH_EQ_LEAD: return PH_PICTURE;
            PH_PICTURE: return PH_EQ_TRAIL;
            default:    return PH_VLONG;
        endcase
    endfunction

endpackage

// File: rtl/pal_unit_timer.sv
// Counts clocks inside one unit (a half-line pulse or a full picture line).
module pal_unit_timer #(
    parameter int CYC_W = 11
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [CYC_W-1:0] unit_len_i,
    output logic [CYC_W-1:0] cyc_o,
    output logic             unit_last_o
);
    typedef struct packed {
        logic [CYC_W-1:0] cyc;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic at_last;

    always_comb begin
        at_last = (tmr_q.cyc == unit_len_i - CYC_W'(1));
        tmr_d   = tmr_q;
        if (at_last) begin
            tmr_d.cyc = '0;
        end else begin
            tmr_d.cyc = tmr_q.cyc + CYC_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign cyc_o       = tmr_q.cyc;
    assign unit_last_o = at_last;

endmodule

// File: rtl/pal_frame_seq.sv
// Walks the fixed phase schedule, counting units in each phase.
module pal_frame_seq
    import pal_sync_pkg::*;
#(
    parameter int N_VLONG    = 5,
    parameter int N_EQ_LEAD  = 5,
    parameter int N_LINES    = 304,
    parameter int N_EQ_TRAIL = 6,
    parameter int CNT_W      = 9
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             unit_last_i,
    output pal_phase_e       phase_o,
    output logic [CNT_W-1:0] unit_idx_o
);
    typedef struct packed {
        pal_phase_e       phase;
        logic [CNT_W-1:0] cnt;
    } seq_t;

    localparam logic [CNT_W-1:0] LAST_VLONG = CNT_W'(N_VLONG - 1);
    localparam logic [CNT_W-1:0] LAST_LEAD  = CNT_W'(N_EQ_LEAD - 1);
    localparam logic [CNT_W-1:0] LAST_LINE  = CNT_W'(N_LINES - 1);
    localparam logic [CNT_W-1:0] LAST_TRAIL = CNT_W'(N_EQ_TRAIL - 1);

    seq_t seq_d, seq_q;
    logic [CNT_W-1:0] last_cnt;

    always_comb begin
        case (seq_q.phase)
            PH_VLONG:   last_cnt = LAST_VLONG;
            PH_EQ_LEAD: last_cnt = LAST_LEAD;
            PH_PICTURE: last_cnt = LAST_LINE;
            default:    last_cnt = LAST_TRAIL;
        endcase

        seq_d = seq_q;
        if (unit_last_i) begin
            if (seq_q.cnt == last_cnt) begin
                seq_d.phase = phase_after(seq_q.phase);
                seq_d.cnt   = '0;
            end else begin
                seq_d.cnt   = seq_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            seq_q <= '{phase: PH_VLONG, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    assign phase_o    = seq_q.phase;
    assign unit_idx_o = seq_q.cnt;

endmodule

// File: rtl/pal_line_index.sv
// Picture-line index: steps once per picture line, holds in the vertical interval.
module pal_line_index
    import pal_sync_pkg::*;
#(
    parameter int N_EQ_LEAD = 5,
    parameter int N_LINES   = 304,
    parameter int CNT_W     = 9,
    parameter int IDX_W     = 9
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  pal_phase_e       phase_i,
    input  logic [CNT_W-1:0] unit_idx_i,
    input  logic             unit_last_i,
    output logic [IDX_W-1:0] line_idx_o
);
    typedef struct packed {
        logic [IDX_W-1:0] idx;
    } lidx_t;

    lidx_t li_d, li_q;
    logic  step_in_pic;
    logic  enter_pic;

    always_comb begin
        step_in_pic = unit_last_i && (phase_i == PH_PICTURE)
                      && (unit_idx_i != CNT_W'(N_LINES - 1));
        enter_pic   = unit_last_i && (phase_i == PH_EQ_LEAD)
                      && (unit_idx_i == CNT_W'(N_EQ_LEAD - 1));
        li_d = li_q;
        if (enter_pic) begin
            li_d.idx = '0;
        end else if (step_in_pic) begin
            li_d.idx = li_q.idx + IDX_W'(1);
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            li_q <= '0;
        end else begin
            li_q <= li_d;
        end
    end

    assign line_idx_o = li_q.idx;

endmodule

// File: rtl/pal_timing_decode.sv
// Turns phase, unit number and cycle position into the sync, window and strobes.
module pal_timing_decode
    import pal_sync_pkg::*;
#(
    parameter int CYC_W        = 11,
    parameter int CNT_W        = 9,
    parameter int LONG_LOW_CYC = 720,
    parameter int EQ_LOW_CYC   = 48,
    parameter int HSYNC_CYC    = 96,
    parameter int ACT_BEGIN    = 288,
    parameter int ACT_END      = 1536
) (
    input  logic             rst_i,
    input  pal_phase_e       phase_i,
    input  logic [CNT_W-1:0] unit_idx_i,
    input  logic [CYC_W-1:0] cyc_i,
    output logic             sync_n_o,
    output logic             active_o,
    output logic             line_start_o,
    output logic             frame_start_o
);
    logic [CYC_W-1:0] low_len;
    logic             unit_head;

    always_comb begin
        case (phase_i)
            PH_VLONG:   low_len = CYC_W'(LONG_LOW_CYC);
            PH_PICTURE: low_len = CYC_W'(HSYNC_CYC);
            default:    low_len = CYC_W'(EQ_LOW_CYC);
        endcase
        unit_head     = (cyc_i == '0);
        sync_n_o      = (cyc_i >= low_len);
        active_o      = (phase_i == PH_PICTURE)
                        && (cyc_i >= CYC_W'(ACT_BEGIN))
                        && (cyc_i <  CYC_W'(ACT_END));
        line_start_o  = !rst_i && unit_head && (phase_i == PH_PICTURE);
        frame_start_o = !rst_i && unit_head && (phase_i == PH_VLONG)
                        && (unit_idx_i == '0);
    end

endmodule

// File: rtl/pal_sync_gen.sv
module pal_sync_gen
    import pal_sync_pkg::*;
#(
    parameter int CLK_PER_US  = 24,
    parameter int HALF_US     = 32,
    parameter int LONG_LOW_US = 30,
    parameter int EQ_LOW_US   = 2,
    parameter int HSYNC_US    = 4,
    parameter int PORCH_US    = 8,
    parameter int ACTIVE_US   = 52,
    parameter int N_VLONG     = 5,
    parameter int N_EQ_LEAD   = 5,
    parameter int N_LINES     = 304,
    parameter int N_EQ_TRAIL  = 6,
    parameter int IDX_W       = $clog2(N_LINES)
) (
    input  logic             clk_i,
    input  logic             rst_i,
    output logic             sync_n_o,
    output logic             active_o,
    output logic             line_start_o,
    output logic             frame_start_o,
    output logic [IDX_W-1:0] line_idx_o
);
    localparam int HALF_CYC  = HALF_US * CLK_PER_US;
    localparam int LINE_CYC  = 2 * HALF_CYC;
    localparam int ACT_BEGIN = (HSYNC_US + PORCH_US) * CLK_PER_US;
    localparam int ACT_END   = ACT_BEGIN + ACTIVE_US * CLK_PER_US;
    localparam int CYC_W     = $clog2(LINE_CYC + 1);
    localparam int N_MAX_A   = (N_VLONG > N_EQ_LEAD) ? N_VLONG : N_EQ_LEAD;
    localparam int N_MAX_B   = (N_LINES > N_EQ_TRAIL) ? N_LINES : N_EQ_TRAIL;
    localparam int N_MAX     = (N_MAX_A > N_MAX_B) ? N_MAX_A : N_MAX_B;
    localparam int CNT_W     = $clog2(N_MAX + 1);

    pal_phase_e       phase;
    logic [CNT_W-1:0] unit_idx;
    logic [CYC_W-1:0] unit_len;
    logic [CYC_W-1:0] cyc;
    logic             unit_last;

    always_comb begin
        unit_len = (phase == PH_PICTURE) ? CYC_W'(LINE_CYC) : CYC_W'(HALF_CYC);
    end

    pal_unit_timer #(.CYC_W(CYC_W)) u_timer (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .unit_len_i  (unit_len),
        .cyc_o       (cyc),
        .unit_last_o (unit_last)
    );

    pal_frame_seq #(
        .N_VLONG    (N_VLONG),
        .N_EQ_LEAD  (N_EQ_LEAD),
        .N_LINES    (N_LINES),
        .N_EQ_TRAIL (N_EQ_TRAIL),
        .CNT_W      (CNT_W)
    ) u_seq (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .unit_last_i (unit_last),
        .phase_o     (phase),
        .unit_idx_o  (unit_idx)
    );

    pal_line_index #(
        .N_EQ_LEAD (N_EQ_LEAD),
        .N_LINES   (N_LINES),
        .CNT_W     (CNT_W),
        .IDX_W     (IDX_W)
    ) u_lidx (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .phase_i     (phase),
        .unit_idx_i  (unit_idx),
        .unit_last_i (unit_last),
        .line_idx_o  (line_idx_o)
    );

    pal_timing_decode #(
        .CYC_W        (CYC_W),
        .CNT_W        (CNT_W),
        .LONG_LOW_CYC (LONG_LOW_US * CLK_PER_US),
        .EQ_LOW_CYC   (EQ_LOW_US * CLK_PER_US),
        .HSYNC_CYC    (HSYNC_US * CLK_PER_US),
        .ACT_BEGIN    (ACT_BEGIN),
        .ACT_END      (ACT_END)
    ) u_dec (
        .rst_i         (rst_i),
        .phase_i       (phase),
        .unit_idx_i    (unit_idx),
        .cyc_i         (cyc),
        .sync_n_o      (sync_n_o),
        .active_o      (active_o),
        .line_start_o  (line_start_o),
        .frame_start_o (frame_start_o)
    );

endmodule

// File: rtl/pal_sync_chk.sv
module pal_sync_chk #(
    parameter int ACT_CYC = 1248,
    parameter int IDX_W   = 9
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             sync_n,
    input logic             active,
    input logic             line_start,
    input logic             frame_start,
    input logic [IDX_W-1:0] line_idx
);
    localparam int RUN_W = $clog2(ACT_CYC + 2) + 1;

    logic [RUN_W-1:0] run_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q <= '0;
        end else if (active) begin
            run_q <= run_q + RUN_W'(1);
        end else begin
            run_q <= '0;
        end
    end

    // R5
    active_outside_sync_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        active |-> sync_n);

    // R5
    active_run_len_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(active) |-> (run_q == RUN_W'(ACT_CYC)));

    // R5
    active_no_overrun_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        active |-> (run_q < RUN_W'(ACT_CYC)));

    // R7
    line_strobe_in_sync_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        line_start |-> (!sync_n && !frame_start));

    // R8
    frame_strobe_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_start |=> !frame_start);

    // R8
    frame_strobe_in_sync_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        frame_start |-> (!sync_n && !active));

    // R9
    index_moves_on_line_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (line_idx != $past(line_idx)) |-> line_start);

endmodule

bind pal_sync_gen pal_sync_chk #(
    .ACT_CYC (ACTIVE_US * CLK_PER_US),
    .IDX_W   (IDX_W)
) u_chk (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .sync_n      (sync_n_o),
    .active      (active_o),
    .line_start  (line_start_o),
    .frame_start (frame_start_o),
    .line_idx    (line_idx_o)
);

// File: tb/sim_pal_sync_gen.sv
`timescale 1ns/100ps
module sim_pal_sync_gen;
    localparam int CPU = 2;
    localparam int NV  = 5;
    localparam int NE  = 5;
    localparam int NL  = 6;
    localparam int NT  = 6;
    localparam int IW  = $clog2(NL);
    localparam int H   = 32 * CPU;
    localparam int L   = 2 * H;
    localparam int FR  = (NV + NE + NT) * H + NL * L;
    localparam int ACT = 52 * CPU;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sync_n, active, line_start, frame_start;
    logic [IW-1:0] line_idx;

    always #2.5 clk = ~clk;

    pal_sync_gen #(.CLK_PER_US(CPU), .N_LINES(NL)) u0 (
        .clk_i(clk), .rst_i(rst), .sync_n_o(sync_n), .active_o(active),
        .line_start_o(line_start), .frame_start_o(frame_start),
        .line_idx_o(line_idx)
    );

    int errs = 0;
    int checks = 0;
    int p = 0;
    int exp_idx = 0;
    int falls = 0;
    int run = 0;
    bit prev_sync = 1'b1;
    bit done = 1'b0;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s at pos %0d: actual=%0d expected=%0d", req, p, act, exp);
        end
    endtask

    // Behavioural reference for the current frame position p.
    task automatic compare();
        int pre, q, c;
        bit low, act, ls, fs;
        string tag;
        pre = (NV + NE) * H;
        act = 1'b0; ls = 1'b0; fs = 1'b0;
        if (p < NV * H) begin
            c = p % H; low = (c < 30 * CPU); fs = (p == 0); tag = "R2";
        end else if (p < pre) begin
            c = (p - NV * H) % H; low = (c < 2 * CPU); tag = "R3";
        end else if (p < pre + NL * L) begin
            q = p - pre; c = q % L;
            low = (c < 4 * CPU);
            act = (c >= 12 * CPU) && (c < 12 * CPU + ACT);
            ls = (c == 0);
            exp_idx = q / L;
            tag = "R4";
        end else begin
            c = (p - pre - NL * L) % H; low = (c < 2 * CPU); tag = "R6";
        end
        chk(tag, int'(sync_n), int'(!low));
        chk("R5", int'(active), int'(act));
        chk("R7", int'(line_start), int'(ls));
        chk("R8", int'(frame_start), int'(fs));
        chk("R9", int'(line_idx), exp_idx);

        if (p == 0) falls = 0;
        if (prev_sync && !sync_n) falls++;
        prev_sync = sync_n;
        if (p == FR - 1) chk("R6", falls, NV + NE + NL + NT);
        if (active) run++;
        else if (run > 0) begin
            chk("R5", run, ACT);
            run = 0;
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            compare();
            p = (p + 1) % FR;
            @(negedge clk); #1;
        end
    endtask

    task automatic check_reset_state();
        chk("R1", int'(sync_n), 0);
        chk("R1", int'(active), 0);
        chk("R1", int'(line_start), 0);
        chk("R1", int'(frame_start), 0);
        chk("R1", int'(line_idx), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check_reset_state();
        rst = 1'b0;
        #0.5;
        p = 0; exp_idx = 0; prev_sync = 1'b1; run = 0;
        step(2 * FR);
        // Reset again inside a picture line, at a point where the window is closed.
        step((NV + NE) * H + 2 * L + 10 - p);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); #1;
        check_reset_state();
        rst = 1'b0;
        #0.5;
        p = 0; exp_idx = 0; prev_sync = 1'b1; run = 0; falls = 0;
        step(FR + FR / 2);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (30000) @(posedge clk);
        if (!done) begin
            checks++;
            errs++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule